// File: doc/BRIEF.md
# Descriptor-chained DMA channel

This block is one channel of a direct memory access engine that follows a chain of descriptors stored in memory. Software writes the address of the first descriptor into a configuration register and starts the channel. The channel reads each 8-byte descriptor over a request/response memory read port. It moves the data the descriptor describes, steps to the next descriptor eight bytes further on, and stops once it has handled the descriptor flagged as the final one. A one-cycle `done` pulse marks a chain that ran to the end. Faults in a descriptor stop the walk and set a sticky error bit. The error bits stay set until the next start.

One parameter, `IS_RX`, chooses the direction. A receive channel takes 32-bit words from a device stream and writes them to memory. It can also flag the last word of each fixed-length row for line-based (video) buffers. A transmit channel reads words from memory and offers them on a device output stream.

Every data path uses valid/ready. A transfer happens on a cycle where both valid and ready are high. Once raised, valid and its payload stay unchanged until accepted. The one exception is an abort of a receive channel, which may withdraw a pending request. In receive mode `dev_in_ready` follows `mem_wr_ready`, so memory back-pressure reaches the device directly. A read request can have only one response outstanding. Responses come back in order and cannot be stalled.

Top module: `sg_desc_dma`

## Requirements
- R1: After reset `busy`, `done`, `err`, `rd_req_valid`, `mem_wr_valid` and `dev_out_valid` are all 0.
- R2: For a descriptor at byte address P, the channel reads a header word at P and a buffer-address word at P+4. Header bits [7:0] are flags: bit 0 valid, bit 1 last, bit 5 transfer. Header bits [31:16] give the length in bytes. A read request keeps its address stable until it is accepted.
- R3: A receive channel moves length/4 words from `dev_in` to memory at the buffer address, B, B+4, and so on, in order. `mem_wr_valid` follows `dev_in_valid`, and `dev_in_ready` follows `mem_wr_ready`.
- R4: A transmit channel reads the buffer words in address order and presents each one on `dev_out_data`. Valid and data stay unchanged until `dev_out_ready`.
- R5: The next descriptor is at P+8. After the descriptor marked last completes, `done` is high for exactly one cycle, `busy` is 0 in that cycle, and no further requests follow.
- R6: A descriptor with the valid bit clear stops the walk without moving data and without `done`, and sets `err[0]`. Both error bits clear on the next start.
- R7: A valid descriptor whose length is not a multiple of 4 stops the walk without moving data and without `done`, and sets `err[1]`.
- R8: A valid descriptor with the transfer bit clear, or with length 0, moves nothing. The walk goes on to the next descriptor, or finishes with `done` if that descriptor is marked last.
- R9: Configuration writes decode on these offsets:
  - Offset 0x04 loads the list base address. On a transmit channel, this write also starts the walk.
  - A receive channel starts only when it is written 1 in bit 0 of offset 0x14.
  - A transmit channel ignores offset 0x14.
  - A receive channel does not start on a write to 0x04.
  - Offset 0x00 is accepted and has no effect.
- R10: On a receive channel, writing 0 in bit 0 of offset 0x14 aborts the walk. No further memory writes occur, `done` stays low, and `busy` falls within 3 cycles.
- R11: On a receive channel, a nonzero value at offset 0x30 sets a row length in bytes, taken from the low 16 bits. `mem_wr_eol` is high with each write that brings the bytes counted since the start, or since the previous marker, to at least that value. A value of 0 disables the marker.
- R12: A start request that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory read request accepted |
| rd_req_addr | output | 32 | Memory read byte address |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | 32 | Read response word |
| mem_wr_valid | output | 1 | Memory write valid (receive) |
| mem_wr_ready | input | 1 | Memory write accepted |
| mem_wr_addr | output | 32 | Memory write byte address |
| mem_wr_data | output | 32 | Memory write word |
| mem_wr_eol | output | 1 | Row-end marker for the current write |
| dev_in_valid | input | 1 | Device input stream valid |
| dev_in_ready | output | 1 | Device input stream ready |
| dev_in_data | input | 32 | Device input word |
| dev_out_valid | output | 1 | Device output stream valid |
| dev_out_ready | input | 1 | Device output stream ready |
| dev_out_data | output | 32 | Device output word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle chain-complete pulse |
| err | output | 2 | Sticky errors: bit 0 invalid descriptor, bit 1 bad length |

## Verification
A wrong walk pointer shows at the memory read port as soon as the next header request goes out, which is at most one cycle after the previous descriptor finishes. A wrong buffer pointer or word count shows in the addresses and the number of words captured on the write or device-output side. A stuck or skipped last flag shows either as a missing `done` or as extra header reads and extra data beats after the end of the chain. A wrong row accumulator shows as a misplaced `mem_wr_eol` on the first row boundary of a walk. The bench runs each case twice, once without back-pressure and once with periodic stalls on every handshake, so that errors which depend on stalls also reach the ports.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  localparam int unsigned CFG_AW     = 8;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned LEN_W      = 16;
  localparam int unsigned STEP_BYTES = 8;

  localparam logic [CFG_AW-1:0] OFF_LIST_LO = 8'h04;
  localparam logic [CFG_AW-1:0] OFF_RUN     = 8'h14;
  localparam logic [CFG_AW-1:0] OFF_ROWLEN  = 8'h30;

  localparam int unsigned FLG_VALID = 0;
  localparam int unsigned FLG_LAST  = 1;
  localparam int unsigned FLG_XFER  = 5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR_REQ, ST_HDR_WAIT, ST_PTR_REQ, ST_PTR_WAIT, ST_CHECK,
    ST_MOVE, ST_FETCH_REQ, ST_FETCH_WAIT, ST_SEND, ST_NEXT, ST_DRAIN
  } walk_state_e;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [7:0]       flags;
  } hdr_t;
endpackage

// File: rtl/sgd_cfg.sv
module sgd_cfg
  import sgd_pkg::*;
#(
  parameter bit IS_RX = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] base_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              row_wr_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_o  <= '0;
      start_o <= 1'b0;
      stop_o  <= 1'b0;
    end else begin
      start_o <= 1'b0;
      stop_o  <= 1'b0;
      if (wr_i && addr_i == OFF_LIST_LO) begin
        base_o  <= wdata_i;
        start_o <= !IS_RX;
      end
      if (IS_RX && wr_i && addr_i == OFF_RUN) begin
        start_o <= wdata_i[0];
        stop_o  <= !wdata_i[0];
      end
    end
  end

  assign row_wr_o = IS_RX && wr_i && (addr_i == OFF_ROWLEN);
endmodule

// File: rtl/sgd_row.sv
module sgd_row #(
  parameter int unsigned ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [ROW_W-1:0] load_val_i,
  input  logic             restart_i,
  input  logic             beat_i,
  output logic             eol_o
);
  localparam int unsigned ACC_W = ROW_W + 1;

  logic [ROW_W-1:0] row_len;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] acc_next;

  assign acc_next = acc + ACC_W'(4);
  assign eol_o    = (row_len != '0) && (acc_next >= {1'b0, row_len});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_len <= '0;
      acc     <= '0;
    end else begin
      if (load_i) row_len <= load_val_i;
      if (restart_i)   acc <= '0;
      else if (beat_i) acc <= eol_o ? '0 : acc_next;
    end
  end

  // R11: a marked beat restarts the row count
  a_r11_row_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_i && eol_o) |=> (acc == '0));
endmodule

// File: rtl/sgd_walker.sv
module sgd_walker
  import sgd_pkg::*;
#(
  parameter bit IS_RX = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [WORD_W-1:0] base_i,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [WORD_W-1:0] rd_req_addr_o,
  input  logic              rd_rsp_valid_i,
  input  logic [WORD_W-1:0] rd_rsp_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [WORD_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic              launch_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        err_o
);
  localparam int unsigned CNT_W = LEN_W - 2;

  walk_state_e       st;
  hdr_t              hdr;
  logic [WORD_W-1:0] ptr, bufa, word;
  logic [CNT_W-1:0]  left;
  logic              waiting, stop_now;

  assign waiting  = (st == ST_HDR_WAIT) || (st == ST_PTR_WAIT) ||
                    (st == ST_FETCH_WAIT) || (st == ST_DRAIN);
  assign stop_now = stop_i && (st != ST_IDLE);
  assign launch_o = start_i && (st == ST_IDLE) && !stop_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      hdr    <= '0;
      ptr    <= '0;
      bufa   <= '0;
      word   <= '0;
      left   <= '0;
      done_o <= 1'b0;
      err_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (stop_now) begin
        st <= (waiting && !rd_rsp_valid_i) ? ST_DRAIN : ST_IDLE;
      end else begin
        unique case (st)
          ST_IDLE: if (launch_o) begin
            ptr   <= base_i;
            err_o <= '0;
            st    <= ST_HDR_REQ;
          end
          ST_HDR_REQ: if (rd_req_ready_i) st <= ST_HDR_WAIT;
          ST_HDR_WAIT: if (rd_rsp_valid_i) begin
            hdr <= '{len: rd_rsp_data_i[31:16], flags: rd_rsp_data_i[7:0]};
            st  <= ST_PTR_REQ;
          end
          ST_PTR_REQ: if (rd_req_ready_i) st <= ST_PTR_WAIT;
          ST_PTR_WAIT: if (rd_rsp_valid_i) begin
            bufa <= rd_rsp_data_i;
            st   <= ST_CHECK;
          end
          ST_CHECK: begin
            if (!hdr.flags[FLG_VALID]) begin
              err_o[0] <= 1'b1;
              st       <= ST_IDLE;
            end else if (hdr.len[1:0] != 2'b00) begin
              err_o[1] <= 1'b1;
              st       <= ST_IDLE;
            end else if (!hdr.flags[FLG_XFER] || hdr.len == '0) begin
              st <= ST_NEXT;
            end else begin
              left <= hdr.len[LEN_W-1:2];
              st   <= IS_RX ? ST_MOVE : ST_FETCH_REQ;
            end
          end
          ST_MOVE: if (in_valid_i && wr_ready_i) begin
            bufa <= bufa + WORD_W'(4);
            left <= left - CNT_W'(1);
            if (left == CNT_W'(1)) st <= ST_NEXT;
          end
          ST_FETCH_REQ: if (rd_req_ready_i) st <= ST_FETCH_WAIT;
          ST_FETCH_WAIT: if (rd_rsp_valid_i) begin
            word <= rd_rsp_data_i;
            st   <= ST_SEND;
          end
          ST_SEND: if (out_ready_i) begin
            bufa <= bufa + WORD_W'(4);
            left <= left - CNT_W'(1);
            st   <= (left == CNT_W'(1)) ? ST_NEXT : ST_FETCH_REQ;
          end
          ST_NEXT: begin
            if (hdr.flags[FLG_LAST]) begin
              done_o <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              ptr <= ptr + WORD_W'(STEP_BYTES);
              st  <= ST_HDR_REQ;
            end
          end
          ST_DRAIN: if (rd_rsp_valid_i) st <= ST_IDLE;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (st)
      ST_PTR_REQ:   rd_req_addr_o = ptr + WORD_W'(4);
      ST_FETCH_REQ: rd_req_addr_o = bufa;
      default:      rd_req_addr_o = ptr;
    endcase
  end

  assign rd_req_valid_o = (st == ST_HDR_REQ) || (st == ST_PTR_REQ) || (st == ST_FETCH_REQ);
  assign wr_valid_o     = (st == ST_MOVE) && in_valid_i;
  assign in_ready_o     = (st == ST_MOVE) && wr_ready_i;
  assign wr_addr_o      = bufa;
  assign wr_data_o      = in_data_i;
  assign out_valid_o    = (st == ST_SEND);
  assign out_data_o     = word;
  assign busy_o         = (st != ST_IDLE);

  // R2: a pending read request keeps its address
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid_o && !rd_req_ready_i && !stop_i) |=> (rd_req_valid_o && $stable(rd_req_addr_o)));
  // R3: consecutive accepted writes in one descriptor step by one word
  a_r3_wr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_ready_i && left != CNT_W'(1) && !stop_i) |=> (wr_addr_o == $past(wr_addr_o) + WORD_W'(4)));
  // R4: offered output word holds until taken
  a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
  // R5: completion is a single-cycle pulse with the channel idle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o ##1 !done_o));
  // R6: a new error halts the walk at once
  a_r6_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o != 2'b00) |-> (!busy_o && !done_o));
endmodule

// File: rtl/sg_desc_dma.sv
module sg_desc_dma
  import sgd_pkg::*;
#(
  parameter bit          IS_RX = 1'b1,
  parameter int unsigned ROW_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic        rd_req_valid,
  input  logic        rd_req_ready,
  output logic [31:0] rd_req_addr,
  input  logic        rd_rsp_valid,
  input  logic [31:0] rd_rsp_data,
  output logic        mem_wr_valid,
  input  logic        mem_wr_ready,
  output logic [31:0] mem_wr_addr,
  output logic [31:0] mem_wr_data,
  output logic        mem_wr_eol,
  input  logic        dev_in_valid,
  output logic        dev_in_ready,
  input  logic [31:0] dev_in_data,
  output logic        dev_out_valid,
  input  logic        dev_out_ready,
  output logic [31:0] dev_out_data,
  output logic        busy,
  output logic        done,
  output logic [1:0]  err
);
  logic [WORD_W-1:0] base;
  logic start_p, stop_p, row_wr, launch, row_eol;

  sgd_cfg #(.IS_RX(IS_RX)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr), .addr_i(cfg_addr), .wdata_i(cfg_wdata),
    .base_o(base), .start_o(start_p), .stop_o(stop_p), .row_wr_o(row_wr)
  );

  sgd_walker #(.IS_RX(IS_RX)) u_walk (
    .clk(clk), .rst_n(rst_n), .start_i(start_p), .stop_i(stop_p), .base_i(base),
    .rd_req_valid_o(rd_req_valid), .rd_req_ready_i(rd_req_ready), .rd_req_addr_o(rd_req_addr),
    .rd_rsp_valid_i(rd_rsp_valid), .rd_rsp_data_i(rd_rsp_data),
    .wr_valid_o(mem_wr_valid), .wr_ready_i(mem_wr_ready), .wr_addr_o(mem_wr_addr),
    .wr_data_o(mem_wr_data),
    .in_valid_i(dev_in_valid), .in_ready_o(dev_in_ready), .in_data_i(dev_in_data),
    .out_valid_o(dev_out_valid), .out_ready_i(dev_out_ready), .out_data_o(dev_out_data),
    .launch_o(launch), .busy_o(busy), .done_o(done), .err_o(err)
  );

  sgd_row #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n), .load_i(row_wr), .load_val_i(cfg_wdata[ROW_W-1:0]),
    .restart_i(launch), .beat_i(mem_wr_valid && mem_wr_ready), .eol_o(row_eol)
  );

  assign mem_wr_eol = mem_wr_valid && row_eol;
endmodule

// File: tb/test_sg_desc_dma.sv
module test_sg_desc_dma;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] cyc = '0;
  logic stall = 1'b0;
  logic clr = 1'b0;
  logic [31:0] mem [0:255];

  always @(posedge clk) cyc <= cyc + 1;

  // receive instance signals
  logic r_cw = 0; logic [7:0] r_ca = 0; logic [31:0] r_cd = 0;
  logic r_rqv, r_rqr, r_rsv; logic [31:0] r_rqa, r_rsd;
  logic r_wv, r_wr_rdy, r_eol; logic [31:0] r_wa, r_wd;
  logic r_iv, r_ir; logic [31:0] r_id; logic [31:0] sidx;
  logic r_ov; logic [31:0] r_od; logic r_busy, r_done; logic [1:0] r_err;
  // transmit instance signals
  logic t_cw = 0; logic [7:0] t_ca = 0; logic [31:0] t_cd = 0;
  logic t_rqv, t_rqr, t_rsv; logic [31:0] t_rqa, t_rsd;
  logic t_wv, t_eol, t_ir; logic [31:0] t_wa, t_wd;
  logic t_ov, t_or; logic [31:0] t_od; logic t_busy, t_done; logic [1:0] t_err;

  assign r_rqr    = !stall || (cyc % 3 != 0);
  assign t_rqr    = !stall || (cyc % 3 != 0);
  assign r_wr_rdy = !stall || (cyc % 4 != 1);
  assign t_or     = !stall || (cyc % 5 != 2);
  assign r_id     = 32'hA000_0000 + sidx;

  sg_desc_dma #(.IS_RX(1'b1)) i_sg_desc_dma (
    .clk(clk), .rst_n(rst_n), .cfg_wr(r_cw), .cfg_addr(r_ca), .cfg_wdata(r_cd),
    .rd_req_valid(r_rqv), .rd_req_ready(r_rqr), .rd_req_addr(r_rqa),
    .rd_rsp_valid(r_rsv), .rd_rsp_data(r_rsd),
    .mem_wr_valid(r_wv), .mem_wr_ready(r_wr_rdy), .mem_wr_addr(r_wa), .mem_wr_data(r_wd),
    .mem_wr_eol(r_eol), .dev_in_valid(r_iv), .dev_in_ready(r_ir), .dev_in_data(r_id),
    .dev_out_valid(r_ov), .dev_out_ready(1'b1), .dev_out_data(r_od),
    .busy(r_busy), .done(r_done), .err(r_err)
  );

  sg_desc_dma #(.IS_RX(1'b0)) i_sg_desc_dma_tx (
    .clk(clk), .rst_n(rst_n), .cfg_wr(t_cw), .cfg_addr(t_ca), .cfg_wdata(t_cd),
    .rd_req_valid(t_rqv), .rd_req_ready(t_rqr), .rd_req_addr(t_rqa),
    .rd_rsp_valid(t_rsv), .rd_rsp_data(t_rsd),
    .mem_wr_valid(t_wv), .mem_wr_ready(1'b1), .mem_wr_addr(t_wa), .mem_wr_data(t_wd),
    .mem_wr_eol(t_eol), .dev_in_valid(1'b0), .dev_in_ready(t_ir), .dev_in_data(32'h0),
    .dev_out_valid(t_ov), .dev_out_ready(t_or), .dev_out_data(t_od),
    .busy(t_busy), .done(t_done), .err(t_err)
  );

  // memory read responders: one cycle latency
  always @(posedge clk) begin
    r_rsv <= rst_n && r_rqv && r_rqr;
    r_rsd <= mem[r_rqa[9:2]];
    t_rsv <= rst_n && t_rqv && t_rqr;
    t_rsd <= mem[t_rqa[9:2]];
  end

  // receive-side device source
  always @(posedge clk) begin
    if (clr || !rst_n) begin
      r_iv <= 1'b0; sidx <= '0;
    end else begin
      if (r_iv && r_ir) sidx <= sidx + 1;
      if (!r_iv || r_ir) r_iv <= !stall || (cyc % 3 != 1);
    end
  end

  // capture of handshakes, sampled at the falling edge
  logic [31:0] cap_a [0:63]; logic [31:0] cap_d [0:63]; logic cap_e [0:63];
  logic [31:0] tx_d [0:63];
  int rn = 0, tn = 0, rdone = 0, tdone = 0, treq_after = 0;
  always @(negedge clk) begin
    if (clr) begin
      rn = 0; tn = 0; rdone = 0; tdone = 0;
    end else begin
      if (r_wv && r_wr_rdy && rn < 64) begin
        cap_a[rn] = r_wa; cap_d[rn] = r_wd; cap_e[rn] = r_eol; rn = rn + 1;
      end
      if (t_ov && t_or && tn < 64) begin tx_d[tn] = t_od; tn = tn + 1; end
      if (r_done) rdone = rdone + 1;
      if (t_done) tdone = tdone + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg(input bit rx, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    if (rx) begin r_cw = 1; r_ca = a; r_cd = d; end
    else    begin t_cw = 1; t_ca = a; t_cd = d; end
    @(negedge clk);
    r_cw = 0; t_cw = 0;
  endtask

  task automatic clear_caps();
    @(negedge clk); clr = 1;
    repeat (2) @(negedge clk);
    clr = 0;
  endtask

  task automatic wait_idle(input bit rx);
    repeat (4) @(negedge clk);
    while (rx ? r_busy : t_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic put_desc(input int base, input int k, input logic [7:0] flags,
                          input logic [15:0] len, input logic [31:0] bufa);
    mem[(base >> 2) + 2*k]     = {len, 8'h00, flags};
    mem[(base >> 2) + 2*k + 1] = bufa;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hB000_0000 + i;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rx busy", r_busy, 0); chk("R1 rx done", r_done, 0); chk("R1 rx err", r_err, 0);
    chk("R1 rx req", r_rqv, 0); chk("R1 rx wr", r_wv, 0);
    chk("R1 tx busy", t_busy, 0); chk("R1 tx out", t_ov, 0); chk("R1 tx req", t_rqv, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R9: start conditions that must not start
    cfg(1, 8'h04, 32'h100);
    repeat (5) @(negedge clk);
    chk("R9 rx low write no start", r_busy, 0);
    cfg(0, 8'h14, 32'h1);
    repeat (5) @(negedge clk);
    chk("R9 tx run write no start", t_busy, 0);

    for (int s = 0; s < 2; s++) begin
      stall = s[0];

      // A: receive two-descriptor chain, row markers, ignored re-start (R2 R3 R5 R9 R11 R12)
      put_desc(32'h100, 0, 8'h21, 16'd12, 32'h200);
      put_desc(32'h100, 1, 8'h23, 16'd8,  32'h300);
      clear_caps();
      cfg(1, 8'h00, 32'hDEAD_BEEF);
      cfg(1, 8'h04, 32'h100);
      cfg(1, 8'h30, 32'd8);
      cfg(1, 8'h14, 32'h1);
      repeat (2) @(negedge clk);
      cfg(1, 8'h14, 32'h1);
      wait_idle(1);
      chk("R5 rx word count", rn, 5);
      chk("R5 rx done once", rdone, 1);
      chk("R12 rx no restart", r_busy, 0);
      chk("R6 rx err clear", r_err, 0);
      for (int k = 0; k < 5; k++) begin
        logic [31:0] ea;
        ea = (k < 3) ? 32'h200 + 4*k : 32'h300 + 4*(k-3);
        chk("R3 rx addr", cap_a[k], ea);
        chk("R3 rx data", cap_d[k], 32'hA000_0000 + k);
        chk("R11 rx row mark", {31'b0, cap_e[k]}, (k == 1 || k == 3) ? 1 : 0);
      end

      // B: second descriptor not valid (R6)
      put_desc(32'h100, 0, 8'h21, 16'd4, 32'h200);
      put_desc(32'h100, 1, 8'h20, 16'd4, 32'h300);
      clear_caps();
      cfg(1, 8'h30, 32'd0);
      cfg(1, 8'h14, 32'h1);
      wait_idle(1);
      chk("R6 rx err bit", r_err, 2'b01);
      chk("R6 rx words before fault", rn, 1);
      chk("R6 rx no done", rdone, 0);
      chk("R11 rx marker off", {31'b0, cap_e[0]}, 0);

      // C: misaligned length (R7)
      put_desc(32'h100, 0, 8'h23, 16'd6, 32'h200);
      clear_caps();
      cfg(1, 8'h14, 32'h1);
      wait_idle(1);
      chk("R7 rx err bit", r_err, 2'b10);
      chk("R7 rx no data", rn, 0);
      chk("R7 rx no done", rdone, 0);

      // D: skipped entries (R8)
      put_desc(32'h100, 0, 8'h01, 16'd8, 32'h200);
      put_desc(32'h100, 1, 8'h21, 16'd0, 32'h240);
      put_desc(32'h100, 2, 8'h23, 16'd4, 32'h300);
      clear_caps();
      cfg(1, 8'h14, 32'h1);
      wait_idle(1);
      chk("R8 rx one word", rn, 1);
      chk("R8 rx addr", cap_a[0], 32'h300);
      chk("R8 rx done", rdone, 1);
      chk("R8 rx err", r_err, 0);

      // E: abort (R10)
      put_desc(32'h100, 0, 8'h23, 16'd64, 32'h200);
      clear_caps();
      cfg(1, 8'h14, 32'h1);
      while (rn < 3) @(negedge clk);
      cfg(1, 8'h14, 32'h0);
      repeat (3) @(negedge clk);
      chk("R10 rx busy falls", r_busy, 0);
      begin
        int n0;
        n0 = rn;
        repeat (20) @(negedge clk);
        chk("R10 rx no more writes", rn, n0);
        chk("R10 rx partial", (n0 < 16) ? 1 : 0, 1);
      end
      chk("R10 rx no done", rdone, 0);

      // F: transmit chain with ignored second start (R4 R5 R9 R12)
      put_desc(32'h180, 0, 8'h21, 16'd8,  32'h200);
      put_desc(32'h180, 1, 8'h23, 16'd12, 32'h300);
      put_desc(32'h1C0, 0, 8'h00, 16'd4,  32'h200);
      clear_caps();
      cfg(0, 8'h04, 32'h180);
      repeat (2) @(negedge clk);
      cfg(0, 8'h04, 32'h1C0);
      wait_idle(0);
      chk("R5 tx word count", tn, 5);
      chk("R5 tx done once", tdone, 1);
      chk("R12 tx err", t_err, 0);
      for (int k = 0; k < 5; k++) begin
        logic [31:0] ew;
        ew = (k < 2) ? 32'hB000_0000 + 32'h80 + k : 32'hB000_0000 + 32'hC0 + (k-2);
        chk("R4 tx data", tx_d[k], ew);
      end

      // G: transmit zero-length last entry (R8)
      put_desc(32'h1C0, 0, 8'h23, 16'd0, 32'h200);
      clear_caps();
      cfg(0, 8'h04, 32'h1C0);
      wait_idle(0);
      chk("R8 tx no data", tn, 0);
      chk("R8 tx done", tdone, 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule